// File: doc/BRIEF.md
# Eight-bit binary add/subtract flag unit

This block performs the binary add-with-carry and subtract-with-borrow steps of a classic 8-bit accumulator datapath. It takes two operands, a carry-in bit and an operation select. It returns the 8-bit result together with four status flags: negative, zero, carry and signed overflow. One valid strobe on the input produces a one-cycle result strobe on the next clock. The result and the flags are held in registers and stay unchanged until the next strobe.

When subtracting, the carry works as an inverted borrow. A carry-in of 1 means nothing is borrowed. A carry-out of 0 means the unsigned difference went below zero. The overflow flag reports whether the true signed value of the whole operation, carry included, falls outside -128..127. Decimal correction is not implemented. A request that arrives with the decimal-mode input set is still computed in binary, and the block flags it as unsupported alongside the result.

Top module: `byte_alu_flags`

## Requirements
- R1: With `op_sub` = 0 the result is (A + M + Cin) mod 256.
- R2: With `op_sub` = 1 the result is (A - M - (1 - Cin)) mod 256.
- R3: After an add, `flag_c` is 1 exactly when the unsigned value A + M + Cin is 256 or more.
- R4: After a subtract, `flag_c` is 0 exactly when the unsigned value A - M - (1 - Cin) is below zero, and 1 otherwise.
- R5: `flag_v` is 1 exactly when the signed value of the full operation (operands read as two's complement, carry term included) lies outside -128..127.
- R6: `flag_n` equals bit 7 of the result.
- R7: `flag_z` is 1 exactly when all 8 result bits are zero.
- R8: Result and flags appear on the clock edge after the one that samples `in_valid`. `res_valid` is high for that single cycle, and the outputs hold their values while `in_valid` is low.
- R9: When `bcd_mode` is 1 with the strobe, `dec_reject` is 1 with the result, and the result and flags are still the binary ones. Otherwise `dec_reject` is 0.
- R10: A synchronous active-high `rst` clears `res_data`, all four flags, `dec_reject` and `res_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; samples the operands |
| op_sub | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| opnd_a | input | 8 | Accumulator operand A |
| opnd_b | input | 8 | Memory operand M |
| carry_in | input | 1 | Incoming carry (inverted borrow when subtracting) |
| bcd_mode | input | 1 | Decimal mode request (unsupported) |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 8 | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Signed overflow flag |
| dec_reject | output | 1 | Decimal request reported as unsupported |

## Verification
A hand-worked table covers specific cases in both directions:
- positive and negative overflow;
- overflow caused only by the carry-in;
- wrap to zero with and without overflow;
- a borrow that leaves V clear;
- a subtract of -128 that underflows.

These cases separate V from C and separate the two carry senses. A stepped sweep over both operands, both carry values and both operations then compares every output against an integer model. The integer model uses true signed and unsigned ranges rather than bit formulas. Directed cases cover output hold between strobes, decimal-mode rejection with a binary result, and reset clearing while a strobe is present.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

endpackage

// File: rtl/byte_addsub_core.sv
module byte_addsub_core
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  // Subtract is A + ~M + Cin: carry-in acts as an inverted borrow.
  always_comb begin
    b_eff = (op == OP_SUB) ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
    sum   = wide[DATA_W-1:0];
    cout  = wide[DATA_W];
    // Signed overflow: like-signed inputs yield a result of the other sign.
    ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end
endmodule

// File: rtl/byte_flag_gen.sv
module byte_flag_gen
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] sum,
  input  logic              cout,
  input  logic              ovf,
  output alu_flags_t        flags
);
  always_comb begin
    flags.n = sum[DATA_W-1];
    flags.z = ~|sum;
    flags.c = cout;
    flags.v = ovf;
  end
endmodule

// File: rtl/byte_result_reg.sv
module byte_result_reg
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d_sum,
  input  alu_flags_t        d_flags,
  input  logic              d_reject,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_sum,
  output alu_flags_t        q_flags,
  output logic              q_reject
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid  <= 1'b0;
      q_sum    <= '0;
      q_flags  <= '0;
      q_reject <= 1'b0;
    end else begin
      q_valid <= load;
      if (load) begin
        q_sum    <= d_sum;
        q_flags  <= d_flags;
        q_reject <= d_reject;
      end
    end
  end
endmodule

// File: rtl/byte_alu_flags.sv
module byte_alu_flags
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              op_sub,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              carry_in,
  input  logic              bcd_mode,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v,
  output logic              dec_reject
);
  alu_op_e           op;
  logic [DATA_W-1:0] core_sum;
  logic              core_cout;
  logic              core_ovf;
  alu_flags_t        comb_flags;
  alu_flags_t        reg_flags;

  assign op = alu_op_e'(op_sub);

  byte_addsub_core #(.DATA_W(DATA_W)) u_core (
    .op   (op),
    .a    (opnd_a),
    .b    (opnd_b),
    .cin  (carry_in),
    .sum  (core_sum),
    .cout (core_cout),
    .ovf  (core_ovf)
  );

  byte_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .sum   (core_sum),
    .cout  (core_cout),
    .ovf   (core_ovf),
    .flags (comb_flags)
  );

  byte_result_reg #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (in_valid),
    .d_sum    (core_sum),
    .d_flags  (comb_flags),
    .d_reject (bcd_mode),
    .q_valid  (res_valid),
    .q_sum    (res_data),
    .q_flags  (reg_flags),
    .q_reject (dec_reject)
  );

  assign flag_n = reg_flags.n;
  assign flag_z = reg_flags.z;
  assign flag_c = reg_flags.c;
  assign flag_v = reg_flags.v;
endmodule

// File: rtl/byte_alu_flags_chk.sv
module byte_alu_flags_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              op_sub,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic              carry_in,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_c,
  input logic              flag_v
);
  localparam int EW = DATA_W + 2;

  logic signed [EW-1:0] ea, eb, ssum;
  logic [DATA_W:0]      usum;
  logic                 exp_v, exp_add_c;

  always_comb begin
    ea   = {{2{opnd_a[DATA_W-1]}}, opnd_a};
    eb   = {{2{opnd_b[DATA_W-1]}}, opnd_b};
    ssum = op_sub ? (ea - eb - EW'(1) + EW'(carry_in)) : (ea + eb + EW'(carry_in));
    exp_v = !((ssum[EW-1:DATA_W-1] == '0) || (ssum[EW-1:DATA_W-1] == '1));
    usum  = {1'b0, opnd_a} + {1'b0, opnd_b} + {{DATA_W{1'b0}}, carry_in};
    exp_add_c = usum[DATA_W];
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid); // R8
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && $stable(res_data))); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (flag_v == $past(exp_v))); // R5
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_sub) |=> (flag_c == $past(exp_add_c))); // R3
  AST_NEG_BIT: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (flag_n == res_data[DATA_W-1])); // R6
  AST_ZERO_BIT: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (flag_z == (res_data == '0))); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!res_valid && res_data == '0 && !flag_c && !flag_v)); // R10
endmodule

bind byte_alu_flags byte_alu_flags_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_sub    (op_sub),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .carry_in  (carry_in),
  .res_valid (res_valid),
  .res_data  (res_data),
  .flag_n    (flag_n),
  .flag_z    (flag_z),
  .flag_c    (flag_c),
  .flag_v    (flag_v)
);

// File: tb/sim_byte_alu_flags.sv
module sim_byte_alu_flags;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  // {sub, a, b, cin, exp_res, N, Z, C, V}
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b0, 8'h50, 8'h10, 1'b0, 8'h60, 4'b0000},
    {1'b0, 8'h50, 8'h50, 1'b0, 8'hA0, 4'b1001},
    {1'b0, 8'h7F, 8'h00, 1'b1, 8'h80, 4'b1001},
    {1'b0, 8'hFF, 8'h01, 1'b0, 8'h00, 4'b0110},
    {1'b0, 8'h80, 8'h80, 1'b0, 8'h00, 4'b0111},
    {1'b0, 8'hD0, 8'h90, 1'b0, 8'h60, 4'b0011},
    {1'b0, 8'hFF, 8'hFF, 1'b1, 8'hFF, 4'b1010},
    {1'b1, 8'h50, 8'hF0, 1'b1, 8'h60, 4'b0000},
    {1'b1, 8'h50, 8'hB0, 1'b1, 8'hA0, 4'b1001},
    {1'b1, 8'h00, 8'h00, 1'b0, 8'hFF, 4'b1000},
    {1'b1, 8'h80, 8'h00, 1'b0, 8'h7F, 4'b0011},
    {1'b1, 8'h05, 8'h05, 1'b1, 8'h00, 4'b0110},
    {1'b1, 8'h7F, 8'hFF, 1'b1, 8'h80, 4'b1001}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       op_sub = 1'b0;
  logic [7:0] opnd_a = '0;
  logic [7:0] opnd_b = '0;
  logic       carry_in = 1'b0;
  logic       bcd_mode = 1'b0;
  logic       res_valid;
  logic [7:0] res_data;
  logic       flag_n, flag_z, flag_c, flag_v, dec_reject;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_alu_flags u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in), .bcd_mode(bcd_mode),
    .res_valid(res_valid), .res_data(res_data), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v), .dec_reject(dec_reject)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one strobe on a falling edge; outputs are sampled one falling edge later.
  task automatic apply(input bit s, input logic [7:0] a, input logic [7:0] b,
                       input bit c, input bit dec);
    @(negedge clk);
    op_sub = s; opnd_a = a; opnd_b = b; carry_in = c; bcd_mode = dec; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; bcd_mode = 1'b0;
  endtask

  // Integer model from the requirements.
  task automatic model(input bit s, input int a, input int b, input int c,
                       output int res, output int n, output int z, output int cy, output int v);
    int sa, sb, sv, uv;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    if (s) begin
      uv = a - b - (1 - c); sv = sa - sb - (1 - c);
      cy = (uv >= 0) ? 1 : 0;              // R4
    end else begin
      uv = a + b + c; sv = sa + sb + c;
      cy = (uv >= 256) ? 1 : 0;            // R3
    end
    res = (uv + 512) % 256;                // R1 R2
    v   = (sv < -128 || sv > 127) ? 1 : 0; // R5
    n   = (res >= 128) ? 1 : 0;            // R6
    z   = (res == 0) ? 1 : 0;              // R7
  endtask

  initial begin
    int res, n, z, cy, v;
    repeat (3) @(negedge clk);
    check("R10 reset valid", int'(res_valid), 0);
    check("R10 reset data", int'(res_data), 0);
    check("R10 reset flags", int'({flag_n, flag_z, flag_c, flag_v, dec_reject}), 0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][29], VEC[i][28:21], VEC[i][20:13], VEC[i][12], 1'b0);
      check(VEC[i][29] ? "R2 table result" : "R1 table result", int'(res_data), int'(VEC[i][11:4]));
      check("R6 R7 table N,Z", int'({flag_n, flag_z}), int'(VEC[i][3:2]));
      check(VEC[i][29] ? "R4 table carry" : "R3 table carry", int'(flag_c), int'(VEC[i][1]));
      check("R5 table overflow", int'(flag_v), int'(VEC[i][0]));
      check("R8 table valid", int'(res_valid), 1);
    end

    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 256; a += 17)
        for (int b = 0; b < 256; b += 13)
          for (int c = 0; c < 2; c++) begin
            model(s[0], a, b, c, res, n, z, cy, v);
            apply(s[0], a[7:0], b[7:0], c[0], 1'b0);
            check(s[0] ? "R2 sweep" : "R1 sweep", int'(res_data), res);
            check(s[0] ? "R4 sweep carry" : "R3 sweep carry", int'(flag_c), cy);
            check("R5 sweep overflow", int'(flag_v), v);
            check("R6 R7 sweep N,Z", int'({flag_n, flag_z}), n * 2 + z);
            check("R9 reject low", int'(dec_reject), 0);
          end

    // R8: single-cycle strobe and hold while idle with changing inputs.
    apply(1'b0, 8'h12, 8'h34, 1'b0, 1'b0);
    check("R8 valid pulse", int'(res_valid), 1);
    opnd_a = 8'hFF; opnd_b = 8'hFF; carry_in = 1'b1; op_sub = 1'b1;
    @(negedge clk);
    check("R8 valid drops", int'(res_valid), 0);
    check("R8 hold data", int'(res_data), 8'h46);
    @(negedge clk);
    check("R8 hold flags", int'({flag_n, flag_z, flag_c, flag_v}), 0);

    // R9: decimal request flagged, arithmetic stays binary (0x19+0x28 = 0x41).
    apply(1'b0, 8'h19, 8'h28, 1'b0, 1'b1);
    check("R9 reject set", int'(dec_reject), 1);
    check("R9 binary result", int'(res_data), 8'h41);
    apply(1'b0, 8'h01, 8'h01, 1'b0, 1'b0);
    check("R9 reject cleared", int'(dec_reject), 0);

    // R10: reset with a strobe present still clears.
    apply(1'b0, 8'hFF, 8'hFF, 1'b1, 1'b1);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R10 clear valid", int'(res_valid), 0);
    check("R10 clear data", int'(res_data), 0);
    check("R10 clear flags", int'({flag_n, flag_z, flag_c, flag_v, dec_reject}), 0);
    in_valid = 1'b0; rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    for (int k = 0; k < 150000 && !done; k++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule